// File: doc/BRIEF.md
# Interface Watchdog with Fallback Channel Control

This block watches a serial host link for well-formed frames and watches the logic supply for undervoltage. A free-running window, measured in base time units made from the system clock, is restarted by every good frame. If the window runs out, the block records a watchdog error. It pulls an active-low fault pin and sets a sticky error bit. Supply loss counts as a missed frame, because frames that arrive while the supply flag is high are not accepted. As a result, an undervoltage that lasts longer than the window also produces the error.

Four window lengths can be selected, spanning 400 µs to 1200 ms at the default parameters. A variant input picks one of two fault reactions. With the fallback variant, the per-channel output controls switch from the normal on bits to a set of fallback bits while the error is live. With the other variant, the outputs keep following the normal on bits and only the fault pin reports the error. The next good frame ends the live error. The sticky bit clears only when the status register is read while no error is live.

Top module: `spi_wdog_lh`

## Requirements
- R1: After a restart, the live error sets exactly LIM_x × CLK_PER_UNIT clock edges later. LIM_x is chosen by `to_sel_i`: 00 selects LIM_A, 01 selects LIM_B, 10 selects LIM_C and 11 selects LIM_D.
- R2: A clock edge that sees `frame_ok_i`=1 and `vdd_uv_i`=0 restarts the window and clears the live error. `frame_ok_i` is a one-cycle pulse for a frame with no length error and no CRC error.
- R3: While `vdd_uv_i`=1, `frame_ok_i` is ignored. A live error stays set, and an undervoltage that outlasts the window raises the error.
- R4: When the error sets, `fault_n_o` goes low and `wd_err_o` goes high on the same edge.
- R5: `wd_err_o` stays set until an edge that sees `gstat_rd_i`=1 while no error is live. A read while the error is live has no effect on it.
- R6: With `limp_var_i`=1 and the error live, `ch_ctl_o` equals `ch_lh_i`. Otherwise it equals `ch_on_i`.
- R7: With `limp_var_i`=0, `ch_ctl_o` equals `ch_on_i` even while the error is live.
- R8: With `wd_en_i`=0, the window is held at its start, no error is raised, and a live error clears on the next edge. `wd_err_o` is not cleared by this.
- R9: A change of `to_sel_i` restarts the window. The error then follows the new length, counted from the edge that saw the change.
- R10: `limp_o` is 1 exactly when the error is live and `limp_var_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wd_en_i | input | 1 | Watchdog enable |
| to_sel_i | input | 2 | Window length select |
| limp_var_i | input | 1 | 1: error forces fallback channel control |
| frame_ok_i | input | 1 | Pulse for a good frame |
| vdd_uv_i | input | 1 | Logic supply undervoltage flag |
| gstat_rd_i | input | 1 | Status register read strobe |
| ch_on_i | input | NCH | Normal per-channel on bits |
| ch_lh_i | input | NCH | Fallback per-channel bits |
| fault_n_o | output | 1 | Active-low fault pin |
| wd_err_o | output | 1 | Sticky watchdog error bit |
| limp_o | output | 1 | Fallback state active |
| ch_ctl_o | output | NCH | Resolved per-channel control |

## Verification
The table runs every window select under both variants. Each run checks the error one edge before and exactly at the expected edge, which separates the four lengths and any off-by-one in either counter. The same runs show whether the channel bus switches to the fallback bits or stays on the normal bits. Directed cases then hold a frame flag high during undervoltage, which separates ignored frames from accepted ones. They switch the select partway through a window, which shows whether a restart happened. They also drop the enable both while the error is live and for a long idle stretch. Reads issued while the error is live and after it has gone show whether the sticky bit is clear-on-read with a condition.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    TSEL_SHORT = 2'b00,
    TSEL_MID   = 2'b01,
    TSEL_LONG  = 2'b10,
    TSEL_MAX   = 2'b11
  } tsel_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned CLK_PER_UNIT = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = $clog2(CLK_PER_UNIT + 1);
  localparam logic [PW-1:0] PLAST = PW'(CLK_PER_UNIT - 1);

  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    tick = !clr && (pc_q == PLAST);
    if (clr || tick) pc_d = '0;
    else             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // Base tick must restart the unit count (R1)
  assert_tick_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pc_q == '0));
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int unsigned UW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [UW-1:0] limit,
  output logic          expire
);
  logic [UW-1:0] uc_q, uc_d;
  logic          at_end;

  always_comb begin
    at_end = (uc_q == limit - 1'b1);
    expire = tick && !clr && at_end;
    if (clr)               uc_d = '0;
    else if (tick && at_end) uc_d = '0;
    else if (tick)         uc_d = uc_q + 1'b1;
    else                   uc_d = uc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uc_q <= '0;
    else        uc_q <= uc_d;
  end

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (uc_q == '0));
  assert_expire_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (uc_q == '0));
endmodule

// File: rtl/wdog_chan_sel.sv
module wdog_chan_sel #(
  parameter int unsigned NCH = 2
) (
  input  logic           use_lh,
  input  logic [NCH-1:0] on_bits,
  input  logic [NCH-1:0] lh_bits,
  output logic [NCH-1:0] ctl
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctl[g] = use_lh ? lh_bits[g] : on_bits[g];
  end
endmodule

// File: rtl/spi_wdog_lh.sv
module spi_wdog_lh
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_PER_UNIT = 8000,
  parameter int unsigned LIM_A = 1,
  parameter int unsigned LIM_B = 1000,
  parameter int unsigned LIM_C = 2000,
  parameter int unsigned LIM_D = 3000,
  parameter int unsigned NCH   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wd_en_i,
  input  logic [1:0]     to_sel_i,
  input  logic           limp_var_i,
  input  logic           frame_ok_i,
  input  logic           vdd_uv_i,
  input  logic           gstat_rd_i,
  input  logic [NCH-1:0] ch_on_i,
  input  logic [NCH-1:0] ch_lh_i,
  output logic           fault_n_o,
  output logic           wd_err_o,
  output logic           limp_o,
  output logic [NCH-1:0] ch_ctl_o
);
  localparam int unsigned LIM_MAX = max4(LIM_A, LIM_B, LIM_C, LIM_D);
  localparam int unsigned UW      = $clog2(LIM_MAX + 1);

  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [1:0]    sel_q;
  logic          live_q, live_d;
  logic          err_q, err_d;
  logic          good_frame, sel_chg, clr, tick, expire;
  logic [UW-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    unique case (tsel_e'(to_sel_i))
      TSEL_SHORT: limit = UW'(LIM_A);
      TSEL_MID:   limit = UW'(LIM_B);
      TSEL_LONG:  limit = UW'(LIM_C);
      default:    limit = UW'(LIM_D);
    endcase
  end

  assign good_frame = frame_ok_i && !vdd_uv_i;
  assign sel_chg    = (to_sel_i != sel_q);
  assign clr        = !wd_en_i || good_frame || sel_chg || live_q;

  wdog_prescale #(.CLK_PER_UNIT(CLK_PER_UNIT)) i_prescale (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .tick(tick)
  );

  wdog_window #(.UW(UW)) i_window (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .tick(tick),
    .limit(limit), .expire(expire)
  );

  always_comb begin
    live_d = live_q;
    if (!wd_en_i || good_frame) live_d = 1'b0;
    else if (expire)            live_d = 1'b1;
    err_d = err_q;
    if (expire)                       err_d = 1'b1;
    else if (gstat_rd_i && !live_q)   err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q  <= 2'b00;
      live_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      sel_q  <= to_sel_i;
      live_q <= live_d;
      err_q  <= err_d;
    end
  end

  assign fault_n_o = !live_q;
  assign wd_err_o  = err_q;
  assign limp_o    = live_q && limp_var_i;

  wdog_chan_sel #(.NCH(NCH)) i_chan (
    .use_lh(limp_o), .on_bits(ch_on_i), .lh_bits(ch_lh_i), .ctl(ch_ctl_o)
  );

  assert_err_with_fault_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(live_q) |-> err_q);
  assert_sticky_err_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_q && !(gstat_rd_i && !live_q)) |=> err_q);
  assert_frame_clears_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wd_en_i && good_frame) |=> !live_q);
  assert_uv_blocks_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live_q && vdd_uv_i && wd_en_i) |=> live_q);
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wd_en_i |=> !live_q);
  assert_limp_follows_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    limp_o |-> (!fault_n_o && limp_var_i && (ch_ctl_o == ch_lh_i)));
  assert_other_variant_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !limp_var_i |-> (ch_ctl_o == ch_on_i));
endmodule

// File: tb/test_spi_wdog_lh.sv
module test_spi_wdog_lh;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int P  = 3;
  localparam int LA = 2, LB = 4, LC = 6, LD = 9;

  // {sel[1:0], variant, window length in clocks[7:0]}
  localparam logic [10:0] VEC [8] = '{
    {2'b00, 1'b1, 8'(LA*P)}, {2'b01, 1'b1, 8'(LB*P)},
    {2'b10, 1'b1, 8'(LC*P)}, {2'b11, 1'b1, 8'(LD*P)},
    {2'b00, 1'b0, 8'(LA*P)}, {2'b01, 1'b0, 8'(LB*P)},
    {2'b10, 1'b0, 8'(LC*P)}, {2'b11, 1'b0, 8'(LD*P)}
  };

  logic clk = 1'b0;
  logic rst_n, en, var_s, fok, uv, rd;
  logic [1:0] sel;
  logic [NCH-1:0] on_b, lh_b, ctl;
  logic fault_n, err, limp;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wdog_lh #(.CLK_PER_UNIT(P), .LIM_A(LA), .LIM_B(LB), .LIM_C(LC), .LIM_D(LD),
                .NCH(NCH)) i_spi_wdog_lh (
    .clk(clk), .rst_n(rst_n), .wd_en_i(en), .to_sel_i(sel), .limp_var_i(var_s),
    .frame_ok_i(fok), .vdd_uv_i(uv), .gstat_rd_i(rd), .ch_on_i(on_b), .ch_lh_i(lh_b),
    .fault_n_o(fault_n), .wd_err_o(err), .limp_o(limp), .ch_ctl_o(ctl)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frame;
    fok = 1'b1; step(1); fok = 1'b0;
  endtask

  task automatic rd_pulse;
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t;
    rst_n = 1'b0; en = 1'b0; var_s = 1'b0; fok = 1'b0; uv = 1'b0; rd = 1'b0;
    sel = 2'b00; on_b = 4'b1010; lh_b = 4'b0101;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("reset R4 fault_n", 32'(fault_n), 1);
    chk("reset R5 wd_err", 32'(err), 0);
    chk("reset R10 limp", 32'(limp), 0);
    chk("reset R6 ch", 32'(ctl), 32'(on_b));
    en = 1'b1;

    for (int i = 0; i < 8; i++) begin
      sel = VEC[i][10:9]; var_s = VEC[i][8]; t = int'(VEC[i][7:0]);
      frame();
      step(t - 1);
      chk("R1 no fault before window", 32'(fault_n), 1);
      step(1);
      chk("R1 fault at window end", 32'(fault_n), 0);
      chk("R4 wd_err set", 32'(err), 1);
      if (var_s) chk("R6 fallback bits", 32'(ctl), 32'(lh_b));
      else       chk("R7 normal bits kept", 32'(ctl), 32'(on_b));
      chk("R10 limp flag", 32'(limp), 32'(var_s));
      rd_pulse();
      chk("R5 read while live keeps err", 32'(err), 1);
      frame();
      chk("R2 frame releases fault", 32'(fault_n), 1);
      chk("R6 control returns", 32'(ctl), 32'(on_b));
      rd_pulse();
      chk("R5 read after clears err", 32'(err), 0);
    end

    // R3: undervoltage blocks frames
    var_s = 1'b1; sel = 2'b00;
    frame();
    uv = 1'b1; fok = 1'b1;
    step(LA*P - 1);
    chk("R3 no fault before window", 32'(fault_n), 1);
    step(1);
    chk("R3 uv outlasting window faults", 32'(fault_n), 0);
    step(2);
    chk("R3 frames ignored under uv", 32'(fault_n), 0);
    chk("R3 fallback held under uv", 32'(ctl), 32'(lh_b));
    uv = 1'b0; step(1); fok = 1'b0;
    chk("R3 frame accepted after uv", 32'(fault_n), 1);
    rd_pulse();

    // R9: select change restarts the window
    sel = 2'b01;
    frame();
    step(5);
    sel = 2'b00;
    step(1);
    step(LA*P - 1);
    chk("R9 no fault before new window", 32'(fault_n), 1);
    step(1);
    chk("R9 fault at new window end", 32'(fault_n), 0);

    // R8: disable clears live error, keeps sticky bit, stays quiet
    en = 1'b0;
    step(1);
    chk("R8 disable clears fault", 32'(fault_n), 1);
    chk("R8 sticky kept on disable", 32'(err), 1);
    rd_pulse();
    chk("R5 read clears after disable", 32'(err), 0);
    step(LD*P*3);
    chk("R8 no fault while disabled", 32'(fault_n), 1);
    chk("R8 no err while disabled", 32'(err), 0);
    chk("R10 no limp while disabled", 32'(limp), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule